// File: doc/BRIEF.md
# High-memory bank switch controller

This block watches a CPU address bus and turns reads in a sixteen-location I/O window at $C080 into a banking configuration for the $D000–$FFFF region. The configuration has three flags: read from ROM, RAM write enable, and bank 2 for the $D000–$DFFF page. From these flags and the current address, the block drives the select lines that route a high-region read to ROM or to RAM, permits or discards a high-region write, and picks the RAM bank for the $Dxxx page.

Switch addresses that would turn on RAM writing are guarded. Such an address takes effect only when the access just before it, as recorded at that access's completion, used the very same address. A single stray read therefore never opens RAM to writes. The block keeps the last completed access address for this comparison. A status location reports the bank-2 flag on data bit 7.

Top module: `hiram_bank_ctrl`

## Requirements
- R1: After reset all three flags are 0 and the recorded previous address is $0000, so the first switch read after reset is never treated as a repeat.
- R2: A completed read whose window offset has bit 0 clear loads the configuration at once: ROM flag = offset bit 1, write flag = 0, bank-2 flag = NOT offset bit 3 ($C080 gives bank-2 only, $C082 gives ROM+bank-2, $C088 clears all, $C08A gives ROM only).
- R3: A completed read whose window offset has bit 0 set, with a recorded previous address equal to the current address, loads ROM flag = offset bit0 XOR bit1, write flag = 1, bank-2 flag = NOT offset bit 3 ($C081 ROM+write+bank-2, $C083 write+bank-2, $C089 ROM+write, $C08B write only).
- R4: A completed odd-offset read whose address differs from the recorded previous address leaves all three flags unchanged.
- R5: The previous address is loaded with the bus address when an access completes (access-complete high), and the repeat test uses the value held before that access; a read with access-complete low changes neither the flags nor the previous address.
- R6: A write anywhere in the $C080–$C08F window changes neither the flags nor the recorded previous address.
- R7: Offset bit 2 is ignored for the configuration, so $C084–$C087 and $C08C–$C08F act as $C080–$C083 and $C088–$C08B; the repeat test still compares the full address.
- R8: A read at $D000 or above asserts the ROM read select when the ROM flag is 1 and the RAM read select when it is 0, never both.
- R9: A write at $D000 or above asserts the RAM write select only while the write flag is 1; otherwise the write is discarded.
- R10: The bank output equals the bank-2 flag for addresses $D000–$DFFF and is 0 for $E000–$FFFF and below $D000.
- R11: A read of $C011 returns bit 7 equal to the bank-2 flag and bits 6:0 zero; reads of the switch window return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | CPU effective address |
| busRead | input | 1 | Read access in progress |
| busWrite | input | 1 | Write access in progress |
| accDone | input | 1 | Current access completes this cycle |
| cfgRom | output | 1 | Flag: high-region reads come from ROM |
| cfgWrEn | output | 1 | Flag: high-region RAM writes allowed |
| cfgBank2 | output | 1 | Flag: $Dxxx page uses RAM bank 2 |
| romRdSel | output | 1 | Route this high-region read to ROM |
| ramRdSel | output | 1 | Route this high-region read to RAM |
| ramWrSel | output | 1 | Commit this high-region write to RAM |
| ramBankHi | output | 1 | RAM bank 2 selected for this access |
| rdData | output | 8 | Data returned for status and switch reads |

## Verification
The two functions that meet in one cycle are the repeat test and the recording of the previous address: on the completing cycle of an odd-offset read, the comparison must use the address saved by the earlier access while the register is being overwritten with the current one. The bench provokes this with back-to-back reads of the same odd address, with the same address split by another read, by a window write, or by an uncompleted read, and with mirror addresses that differ only in bit 2. A scoreboard predicts the flags from the requirements after every access and compares them on the following falling edge.

// File: rtl/hiram_pkg.sv
package hiram_pkg;

  typedef struct packed {
    logic rom;
    logic wrEn;
    logic bank2;
  } bankCfg_t;

  typedef struct packed {
    logic     loadCfg;
    bankCfg_t nextCfg;
    logic     latchAddr;
  } ctrlStrobe_t;

endpackage

// File: rtl/hiram_ctrl.sv
module hiram_ctrl
  import hiram_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC080
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic              accDone,
  input  logic [ADDR_W-1:0] lastAddr,
  output ctrlStrobe_t       strobe
);

  localparam int                OFS_W    = 4;
  localparam logic [ADDR_W-1:0] WIN_MASK = ~ADDR_W'((1 << OFS_W) - 1);

  logic             inWin;
  logic [OFS_W-1:0] ofs;
  logic             needsRepeat;
  logic             isRepeat;

  always_comb begin
    inWin       = (busAddr & WIN_MASK) == WIN_BASE;
    ofs         = busAddr[OFS_W-1:0];
    needsRepeat = ofs[0];
    isRepeat    = lastAddr == busAddr;

    strobe.loadCfg       = busRead && accDone && inWin && (!needsRepeat || isRepeat);
    strobe.nextCfg.rom   = ofs[0] ^ ofs[1];
    strobe.nextCfg.wrEn  = ofs[0];
    strobe.nextCfg.bank2 = ~ofs[3];
    strobe.latchAddr     = accDone && !(busWrite && inWin);
  end

endmodule

// File: rtl/hiram_dp.sv
module hiram_dp
  import hiram_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] HIGH_BASE   = 16'hD000,
  parameter logic [ADDR_W-1:0] BANKED_END  = 16'hE000,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hC011,
  parameter logic [ADDR_W-1:0] RESET_LAST  = 16'h0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  output bankCfg_t          cfg,
  output logic [ADDR_W-1:0] lastAddr,
  output logic              romRdSel,
  output logic              ramRdSel,
  output logic              ramWrSel,
  output logic              ramBankHi,
  output logic [DATA_W-1:0] rdData
);

  logic inHigh;
  logic inBanked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg      <= '0;
      lastAddr <= RESET_LAST;
    end else begin
      if (strobe.loadCfg)   cfg      <= strobe.nextCfg;
      if (strobe.latchAddr) lastAddr <= busAddr;
    end
  end

  always_comb begin
    inHigh    = busAddr >= HIGH_BASE;
    inBanked  = inHigh && (busAddr < BANKED_END);
    romRdSel  = busRead && inHigh && cfg.rom;
    ramRdSel  = busRead && inHigh && !cfg.rom;
    ramWrSel  = busWrite && inHigh && cfg.wrEn;
    ramBankHi = inBanked && cfg.bank2;
    rdData    = '0;
    if (busRead && busAddr == STATUS_ADDR) rdData[DATA_W-1] = cfg.bank2;
  end

  p_addr_latch_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchAddr |=> lastAddr == $past(busAddr));

  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadCfg |=> $stable(cfg));

  p_rd_route_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(romRdSel && ramRdSel));

endmodule

// File: rtl/hiram_bank_ctrl.sv
module hiram_bank_ctrl
  import hiram_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE    = 16'hC080,
  parameter logic [ADDR_W-1:0] HIGH_BASE   = 16'hD000,
  parameter logic [ADDR_W-1:0] BANKED_END  = 16'hE000,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hC011,
  parameter logic [ADDR_W-1:0] RESET_LAST  = 16'h0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic              accDone,
  output logic              cfgRom,
  output logic              cfgWrEn,
  output logic              cfgBank2,
  output logic              romRdSel,
  output logic              ramRdSel,
  output logic              ramWrSel,
  output logic              ramBankHi,
  output logic [DATA_W-1:0] rdData
);

  ctrlStrobe_t       strobe;
  bankCfg_t          cfg;
  logic [ADDR_W-1:0] lastAddr;

  hiram_ctrl #(
    .ADDR_W  (ADDR_W),
    .WIN_BASE(WIN_BASE)
  ) uCtrl (
    .busAddr (busAddr),
    .busRead (busRead),
    .busWrite(busWrite),
    .accDone (accDone),
    .lastAddr(lastAddr),
    .strobe  (strobe)
  );

  hiram_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .HIGH_BASE  (HIGH_BASE),
    .BANKED_END (BANKED_END),
    .STATUS_ADDR(STATUS_ADDR),
    .RESET_LAST (RESET_LAST)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busAddr  (busAddr),
    .busRead  (busRead),
    .busWrite (busWrite),
    .cfg      (cfg),
    .lastAddr (lastAddr),
    .romRdSel (romRdSel),
    .ramRdSel (ramRdSel),
    .ramWrSel (ramWrSel),
    .ramBankHi(ramBankHi),
    .rdData   (rdData)
  );

  assign cfgRom   = cfg.rom;
  assign cfgWrEn  = cfg.wrEn;
  assign cfgBank2 = cfg.bank2;

  logic chkInWin;
  assign chkInWin = (busAddr[ADDR_W-1:4] == WIN_BASE[ADDR_W-1:4]);

  p_even_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && accDone && chkInWin && !busAddr[0]) |=>
      (cfgRom == $past(busAddr[1]) && !cfgWrEn && cfgBank2 == !$past(busAddr[3])));

  p_single_odd_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && accDone && chkInWin && busAddr[0] && lastAddr != busAddr) |=>
      $stable({cfgRom, cfgWrEn, cfgBank2}));

  p_win_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && accDone && chkInWin) |=>
      ($stable({cfgRom, cfgWrEn, cfgBank2}) && $stable(lastAddr)));

  p_wr_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    ramWrSel |-> cfgWrEn);

endmodule

// File: tb/hiram_bank_ctrl_test.sv
module hiram_bank_ctrl_test;

  typedef struct {
    logic [2:0] cfg;
    string      req;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busRead = 1'b0;
  logic        busWrite = 1'b0;
  logic        accDone = 1'b0;
  logic        cfgRom, cfgWrEn, cfgBank2;
  logic        romRdSel, ramRdSel, ramWrSel, ramBankHi;
  logic [7:0]  rdData;

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;
  expItem_t sbq[$];

  logic [2:0]  mdl = 3'b000;
  logic [15:0] lastMdl = 16'h0000;

  hiram_bank_ctrl uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .accDone(accDone), .cfgRom(cfgRom),
    .cfgWrEn(cfgWrEn), .cfgBank2(cfgBank2), .romRdSel(romRdSel),
    .ramRdSel(ramRdSel), .ramWrSel(ramWrSel), .ramBankHi(ramBankHi),
    .rdData(rdData)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one access, comb checks in-cycle, expected flags to scoreboard
  task automatic access(input logic [15:0] a, input bit wr, input bit done, input string req);
    logic [2:0] nxt;
    bit inWin;
    @(negedge clk);
    busAddr = a; busRead = !wr; busWrite = wr; accDone = done;
    #1;
    inWin = (a & 16'hFFF0) == 16'hC080;
    if (!wr && a >= 16'hD000) begin
      chk("R8 romRdSel", 16'(romRdSel), 16'(mdl[2]));
      chk("R8 ramRdSel", 16'(ramRdSel), 16'(!mdl[2]));
    end
    if (wr && a >= 16'hD000) chk("R9 ramWrSel", 16'(ramWrSel), 16'(mdl[1]));
    chk("R10 ramBankHi", 16'(ramBankHi),
        16'((a >= 16'hD000 && a < 16'hE000) ? mdl[0] : 1'b0));
    if (!wr && a == 16'hC011) chk("R11 status", 16'(rdData), {8'h00, mdl[0], 7'h00});
    if (!wr && inWin) chk("R11 window data", 16'(rdData), 16'h0000);
    nxt = mdl;
    if (!wr && done && inWin && (!a[0] || lastMdl == a))
      nxt = {a[0] ^ a[1], a[0], !a[3]};
    if (done && !(wr && inWin)) lastMdl = a;
    @(posedge clk);
    #1;
    busRead = 1'b0; busWrite = 1'b0; accDone = 1'b0;
    mdl = nxt;
    sbq.push_back('{cfg: nxt, req: req});
  endtask

  // monitor
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      expItem_t it;
      it = sbq.pop_front();
      chk(it.req, 16'({cfgRom, cfgWrEn, cfgBank2}), 16'(it.cfg));
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    nChk++; nBad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset flags", 16'({cfgRom, cfgWrEn, cfgBank2}), 16'h0000);
    // R1: first odd read after reset is not a repeat
    access(16'hC081, 0, 1, "R1 first C081 single");
    access(16'hC081, 0, 1, "R3 C081 repeated");
    access(16'hC080, 0, 1, "R2 C080");
    access(16'hC083, 0, 1, "R4 C083 single");
    access(16'hC083, 0, 1, "R3 C083 repeated");
    access(16'hC082, 0, 1, "R2 C082");
    access(16'hC088, 0, 1, "R2 C088");
    access(16'hC08A, 0, 1, "R2 C08A");
    access(16'hC089, 0, 1, "R4 C089 single");
    access(16'hC089, 0, 1, "R3 C089 repeated");
    access(16'hC08B, 0, 1, "R4 C08B single");
    access(16'hC08B, 0, 1, "R3 C08B repeated");
    // R6: window write neither changes flags nor breaks a repeat
    access(16'hC080, 0, 1, "R2 C080 again");
    access(16'hC089, 0, 1, "R4 C089 first");
    access(16'hC088, 1, 1, "R6 write C088");
    access(16'hC089, 0, 1, "R6 C089 repeat across write");
    // R5: an intervening read breaks the repeat
    access(16'hC08B, 0, 1, "R4 C08B first");
    access(16'hD123, 0, 1, "R5 D123 read");
    access(16'hC08B, 0, 1, "R5 C08B not repeat");
    // R5: uncompleted read neither loads nor records
    access(16'hC089, 0, 1, "R5 C089 record");
    access(16'hC08B, 0, 0, "R5 C08B incomplete");
    access(16'hC08B, 0, 1, "R5 C08B after incomplete");
    // R7: mirrors
    access(16'hC084, 0, 1, "R7 C084 as C080");
    access(16'hC085, 0, 1, "R7 C085 single");
    access(16'hC081, 0, 1, "R7 C081 after C085 not repeat");
    access(16'hC08E, 0, 1, "R7 C08E as C08A");
    access(16'hC08F, 0, 1, "R7 C08F single");
    access(16'hC08F, 0, 1, "R7 C08F repeated");
    // R8-R11 under several configurations
    access(16'hD000, 0, 1, "R8 D000 read wr-only");
    access(16'hD000, 1, 1, "R9 D000 write enabled");
    access(16'hC011, 0, 1, "R11 status bank1");
    access(16'hC080, 0, 1, "R2 C080 bank2");
    access(16'hDFFF, 0, 1, "R10 DFFF bank2");
    access(16'hE000, 0, 1, "R10 E000 single bank");
    access(16'hFFFF, 1, 1, "R9 FFFF write discarded");
    access(16'hC011, 0, 1, "R11 status bank2");
    access(16'hC082, 0, 1, "R2 C082 rom");
    access(16'hF800, 0, 1, "R8 F800 rom read");
    access(16'hC081, 0, 1, "R3 C081 first");
    access(16'hC081, 0, 1, "R3 C081 second");
    access(16'hD800, 1, 1, "R9 D800 write enabled");
    access(16'hC000, 0, 1, "R10 below high region");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule